// File: doc/BRIEF.md
# Convergent Rounding and Saturation Unit

This datapath stage takes a 40-bit signed fractional accumulator value. The value has 8 guard bits on top (39:32), a kept high word (31:16) and a low word (15:0) that rounding discards. From that value the stage forms two results. The first is the whole 40-bit value rounded at bit 16. Rounding is either round-half-to-even or two's-complement round-half-up, chosen per sample. The second is a 16-bit word meant for storage to memory. When limiting is enabled and the value has grown past what a 16-bit fraction can hold, that word is clamped to the largest positive or the most negative code.

Each sample is qualified by `in_valid`, and its results appear registered one cycle later. The stored word is taken from either the raw value or the rounded value. A sticky flag records that clamping happened at least once since it was last cleared.

Top module: `rnd_sat_unit`

## Requirements
- R1: While reset is held, and after it is released, `out_valid`, `rnd_out`, `store_word` and `limit_flag` are all zero until the first accepted sample.
- R2: A sample presented with `in_valid` high produces `out_valid` high on the next cycle. Cycles with `in_valid` low give `out_valid` low, and the data outputs keep their last values.
- R3: If the low word (bits 15:0) is below 0x8000, bits 39:16 of `rnd_out` equal the input's bits 39:16.
- R4: If the low word is above 0x8000, one is added at bit 16. The carry ripples through bits 39:16 and wraps modulo 2^24 in that field.
- R5: With `round_even`=1 and the low word exactly 0x8000, one is added at bit 16 only if input bit 16 is 1, so that bit 16 of the result is 0.
- R6: With `round_even`=0, a low word of exactly 0x8000 always adds one at bit 16.
- R7: Bits 15:0 of `rnd_out` are always zero.
- R8: With `sat_en`=1, the source value does not fit when its bits 39:31 are not all equal. In that case `store_word` is 0x7FFF if bit 39 is 0 and 0x8000 if bit 39 is 1.
- R9: With `sat_en`=0, or when the source fits, `store_word` equals bits 31:16 of the source.
- R10: `store_rnd`=1 makes the rounded value the source for `store_word`; `store_rnd`=0 makes the raw input the source.
- R11: `limit_flag` goes high the cycle after an accepted sample is clamped and stays high until `flag_clr` is sampled high. A clamp in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Accept the sample on `acc_in` |
| acc_in | input | 40 | Accumulator value, guard:high:low |
| round_even | input | 1 | 1 = round half to even, 0 = round half up |
| sat_en | input | 1 | 1 = clamp the stored word on overflow |
| store_rnd | input | 1 | 1 = stored word taken from rounded value |
| flag_clr | input | 1 | Clear the sticky limit flag |
| out_valid | output | 1 | Results below belong to a sample |
| rnd_out | output | 40 | Rounded accumulator, low word zero |
| store_word | output | 16 | Word for storage, possibly clamped |
| limit_flag | output | 1 | Sticky: clamping occurred |

## Verification
Several properties are checked on every cycle:
- the one-cycle valid latency and the hold of the outputs between samples;
- the zero low word of the rounded value, and a round-down leaving bits 39:16 untouched;
- the clamp code for raw overflowing samples;
- setting, holding and clearing of the sticky flag.

Only the bench's scenarios show the finer cases. These are the tie decision in each rounding mode, carries rippling through all guard bits (including a negative value wrapping to zero), the choice of source for the stored word, and the clear-versus-set priority.

// File: rtl/rnd_sat_pkg.sv
// Shared definitions for the rounding/limiting stage.
// Assumes: the kept field sits directly above a low word of equal width.
package rnd_sat_pkg;
    typedef enum logic {
        RND_HALF_UP   = 1'b0,
        RND_HALF_EVEN = 1'b1
    } rnd_mode_e;
endpackage

// File: rtl/rnd_core.sv
// Rounds an accumulator at the boundary between the kept word and the low
// word. Ties go to even or upward depending on the mode. The result's low
// word is forced to zero, and the increment ripples through the guard bits
// and wraps.
// Assumes: the input is two's complement; no saturation is applied here.
module rnd_core
    import rnd_sat_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int EXT_W  = 8
) (
    input  logic [EXT_W+2*WORD_W-1:0] acc,
    input  rnd_mode_e                 mode,
    output logic [EXT_W+2*WORD_W-1:0] rounded
);
    localparam int ACC_W = EXT_W + 2 * WORD_W;
    localparam int TOP_W = ACC_W - WORD_W;
    localparam logic [WORD_W-1:0] HALF = {1'b1, {(WORD_W-1){1'b0}}};

    logic [WORD_W-1:0] low;
    logic [TOP_W-1:0]  upper;
    logic              bump;

    // Decide whether the kept field is incremented.
    always_comb begin
        low   = acc[WORD_W-1:0];
        upper = acc[ACC_W-1:WORD_W];
        if (low > HALF)
            bump = 1'b1;
        else if (low == HALF)
            bump = (mode == RND_HALF_EVEN) ? upper[0] : 1'b1;
        else
            bump = 1'b0;
    end

    // Apply the increment and clear the discarded word.
    always_comb begin
        rounded = {upper + TOP_W'(bump), {WORD_W{1'b0}}};
    end
endmodule

// File: rtl/sat_limiter.sv
// Produces the storage word from a full accumulator value. When limiting is
// on and the guard bits plus the word's sign bit disagree, it clamps to the
// extreme code of the accumulator's sign.
// Assumes: the sign of the full value is its most significant bit.
module sat_limiter #(
    parameter int WORD_W = 16,
    parameter int EXT_W  = 8
) (
    input  logic [EXT_W+2*WORD_W-1:0] src,
    input  logic                      sat_en,
    output logic [WORD_W-1:0]         word,
    output logic                      clamped
);
    localparam int ACC_W = EXT_W + 2 * WORD_W;
    localparam int CHK_W = EXT_W + 1;
    localparam logic [WORD_W-1:0] POS_MAX = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] NEG_MAX = {1'b1, {(WORD_W-1){1'b0}}};

    logic [CHK_W-1:0] sign_run;
    logic             fits;

    // The value fits when guard bits and word sign are one repeated bit.
    always_comb begin
        sign_run = src[ACC_W-1:2*WORD_W-1];
        fits     = (&sign_run) | ~(|sign_run);
    end

    // Choose between the plain high word and a clamp code.
    always_comb begin
        clamped = sat_en & ~fits;
        if (clamped)
            word = src[ACC_W-1] ? NEG_MAX : POS_MAX;
        else
            word = src[2*WORD_W-1:WORD_W];
    end
endmodule

// File: rtl/rnd_sat_unit.sv
// Top of the rounding and limiting stage. Rounds each accepted sample,
// derives a storage word from the raw or the rounded value, and registers
// both with one cycle of latency. It also keeps a sticky flag of clamp events.
// Assumes: synchronous active-low reset; data outputs hold between samples.
module rnd_sat_unit
    import rnd_sat_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int EXT_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [EXT_W+2*WORD_W-1:0] acc_in,
    input  logic                      round_even,
    input  logic                      sat_en,
    input  logic                      store_rnd,
    input  logic                      flag_clr,
    output logic                      out_valid,
    output logic [EXT_W+2*WORD_W-1:0] rnd_out,
    output logic [WORD_W-1:0]         store_word,
    output logic                      limit_flag
);
    localparam int ACC_W = EXT_W + 2 * WORD_W;

    logic [ACC_W-1:0]  rounded_c;
    logic [ACC_W-1:0]  store_src_c;
    logic [WORD_W-1:0] word_c;
    logic              clamp_c;
    rnd_mode_e         mode_c;

    // Map the mode pin to the rounding mode type.
    always_comb begin
        mode_c = round_even ? RND_HALF_EVEN : RND_HALF_UP;
    end

    rnd_core #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_round (
        .acc     (acc_in),
        .mode    (mode_c),
        .rounded (rounded_c)
    );

    // Pick the value the storage word is taken from.
    always_comb begin
        store_src_c = store_rnd ? rounded_c : acc_in;
    end

    sat_limiter #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_limit (
        .src     (store_src_c),
        .sat_en  (sat_en),
        .word    (word_c),
        .clamped (clamp_c)
    );

    // Register results for accepted samples; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            rnd_out    <= '0;
            store_word <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                rnd_out    <= rounded_c;
                store_word <= word_c;
            end
        end
    end

    // Sticky clamp flag: a new clamp wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit_flag <= 1'b0;
        else
            limit_flag <= (limit_flag & ~flag_clr) | (in_valid & clamp_c);
    end
endmodule

// File: rtl/rnd_sat_chk.sv
// Property checker for rnd_sat_unit, attached through bind. It observes
// only the top-level ports.
module rnd_sat_chk #(
    parameter int WORD_W = 16,
    parameter int EXT_W  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [EXT_W+2*WORD_W-1:0] acc_in,
    input logic                      sat_en,
    input logic                      store_rnd,
    input logic                      flag_clr,
    input logic                      out_valid,
    input logic [EXT_W+2*WORD_W-1:0] rnd_out,
    input logic [WORD_W-1:0]         store_word,
    input logic                      limit_flag
);
    localparam int ACC_W = EXT_W + 2 * WORD_W;

    logic raw_over;
    assign raw_over = ~((&acc_in[ACC_W-1:2*WORD_W-1]) | ~(|acc_in[ACC_W-1:2*WORD_W-1]));

    p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(rnd_out) && $stable(store_word)));
    p_round_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !acc_in[WORD_W-1]) |=> (rnd_out[ACC_W-1:WORD_W] == $past(acc_in[ACC_W-1:WORD_W])));
    p_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (rnd_out[WORD_W-1:0] == '0));
    p_clamp_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_en && !store_rnd && raw_over && !acc_in[ACC_W-1])
        |=> (store_word == {1'b0, {(WORD_W-1){1'b1}}}));
    p_clamp_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_en && !store_rnd && raw_over && acc_in[ACC_W-1])
        |=> (store_word == {1'b1, {(WORD_W-1){1'b0}}}));
    p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_en && !store_rnd && raw_over) |=> limit_flag);
    p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_flag && !flag_clr) |=> limit_flag);
    p_flag_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !in_valid) |=> !limit_flag);
endmodule

bind rnd_sat_unit rnd_sat_chk #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .acc_in     (acc_in),
    .sat_en     (sat_en),
    .store_rnd  (store_rnd),
    .flag_clr   (flag_clr),
    .out_valid  (out_valid),
    .rnd_out    (rnd_out),
    .store_word (store_word),
    .limit_flag (limit_flag)
);

// File: tb/sim_rnd_sat_unit.sv
// Scoreboard bench: the driver queues expected results, the monitor
// compares them as out_valid appears.
module sim_rnd_sat_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [39:0] acc_in = '0;
    logic        round_even = 1'b0;
    logic        sat_en = 1'b0;
    logic        store_rnd = 1'b0;
    logic        flag_clr = 1'b0;
    logic        out_valid;
    logic [39:0] rnd_out;
    logic [15:0] store_word;
    logic        limit_flag;

    typedef struct {
        logic [39:0] rnd;
        logic [15:0] word;
        logic        flag;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic        model_flag = 1'b0;
    logic [39:0] last_rnd = '0;
    logic [15:0] last_word = '0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    rnd_sat_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_in(acc_in),
        .round_even(round_even), .sat_en(sat_en), .store_rnd(store_rnd),
        .flag_clr(flag_clr), .out_valid(out_valid), .rnd_out(rnd_out),
        .store_word(store_word), .limit_flag(limit_flag)
    );

    // Expected rounding from R3..R7.
    function automatic logic [39:0] model_round(logic [39:0] a, logic even);
        logic [23:0] hi;
        logic        up;
        hi = a[39:16];
        if (a[15:0] > 16'h8000)       up = 1'b1;
        else if (a[15:0] == 16'h8000) up = even ? a[16] : 1'b1;
        else                          up = 1'b0;
        return {hi + {23'd0, up}, 16'h0000};
    endfunction

    task automatic check(input bit ok, input string req, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s", req, msg);
        end
    endtask

    // Drive one sample and queue its expected results.
    task automatic apply(input logic [39:0] a, input logic even, input logic sat,
                         input logic use_rnd, input logic clr, input string req);
        exp_t        e;
        logic [39:0] src;
        logic [8:0]  run;
        logic        hit;
        @(negedge clk);
        in_valid = 1'b1; acc_in = a; round_even = even;
        sat_en = sat; store_rnd = use_rnd; flag_clr = clr;
        e.rnd = model_round(a, even);
        src = use_rnd ? e.rnd : a;
        run = src[39:31];
        hit = sat && !(run == 9'h000 || run == 9'h1FF);
        e.word = hit ? (src[39] ? 16'h8000 : 16'h7FFF) : src[31:16];
        model_flag = (model_flag & ~clr) | hit;
        e.flag = model_flag;
        e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; flag_clr = 1'b0;
        end
    endtask

    // Monitor: compare each result after the edge that produced it.
    always @(posedge clk) begin
        #2;
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2", "out_valid with nothing expected");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rnd_out == e.rnd && store_word == e.word && limit_flag == e.flag, e.req,
                      $sformatf("rnd=%h word=%h flag=%0b exp rnd=%h word=%h flag=%0b",
                                rnd_out, store_word, limit_flag, e.rnd, e.word, e.flag));
                last_rnd  = e.rnd;
                last_word = e.word;
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            check(1'b0, "WDOG", "run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 0 && rnd_out == 0 && store_word == 0 && limit_flag == 0, "R1",
              $sformatf("v=%0b rnd=%h w=%h f=%0b exp all 0", out_valid, rnd_out, store_word, limit_flag));
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 0 && limit_flag == 0, "R1",
              $sformatf("v=%0b f=%0b exp 0 0 after release", out_valid, limit_flag));

        apply(40'h00_1234_7FFF, 1, 0, 0, 0, "R3");
        apply(40'h00_1234_8001, 1, 0, 0, 0, "R4");
        apply(40'h00_1234_8000, 1, 0, 0, 0, "R5");
        apply(40'h00_1235_8000, 1, 0, 0, 0, "R5");
        apply(40'h00_1234_8000, 0, 0, 0, 0, "R6");
        apply(40'hFF_FFFF_C000, 0, 0, 0, 0, "R4");
        apply(40'hFF_C000_0000, 1, 1, 0, 0, "R9");
        apply(40'hFF_7FFF_0000, 1, 0, 0, 0, "R9");
        apply(40'h00_7FFF_8000, 1, 0, 1, 0, "R10");
        apply(40'h00_7FFF_8000, 1, 0, 0, 0, "R10");
        idle(3);
        // R2: outputs held and out_valid low while idle
        check(!out_valid && rnd_out == last_rnd && store_word == last_word, "R2",
              $sformatf("v=%0b rnd=%h w=%h exp 0 %h %h", out_valid, rnd_out, store_word, last_rnd, last_word));
        // R8 and R11: clamps set the sticky flag
        apply(40'h00_FFFF_8001, 1, 1, 1, 0, "R8");
        apply(40'hFF_7FFF_0000, 1, 1, 0, 0, "R8");
        apply(40'h00_0100_0000, 1, 1, 0, 0, "R11");
        idle(2);
        check(limit_flag == 1'b1, "R11", $sformatf("flag=%0b exp 1 held", limit_flag));
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        model_flag = 1'b0;
        check(limit_flag == 1'b0, "R11", $sformatf("flag=%0b exp 0 after clear", limit_flag));
        apply(40'h80_0000_0000, 1, 1, 0, 1, "R11");
        apply(40'h00_0000_0000, 1, 1, 0, 0, "R11");
        // R7: sweep of computed patterns across all modes
        for (int i = 0; i < 64; i++) begin
            logic [39:0] v;
            v = 40'(i) * 40'h13_579B_DF1 + 40'(i << 15);
            apply(v, i[0], i[1], i[2], i[3] & i[4], "R7");
        end
        idle(4);
        check(sb_q.size() == 0, "R2", $sformatf("%0d results missing exp 0", sb_q.size()));
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule